// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits in the receive path of an Ethernet controller, just after the preamble has been stripped. It consumes a 4-bit nibble stream qualified by a valid flag and a clock-enable strobe. It examines the first twelve nibbles, which carry the 48-bit destination address, and compares them against a programmed station address and against the all-ones broadcast address.

With filtering switched on, a frame addressed to the station or to broadcast is forwarded without its destination field, so the first nibble out belongs to the source address. A frame addressed elsewhere raises an address error flag and produces no output, which lets downstream logic discard it. With filtering switched off, every nibble of every frame is forwarded. The mode is taken once per frame, at its first nibble. A broadcast flag reports all-ones destinations in either mode. An abort input drops the current frame until the valid flag falls.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: While reset is held, and after it until the first frame, `out_vld`, `addr_err` and `bcast` are 0.
- R2: In filtering mode, a frame whose destination equals `station_addr` is forwarded from its 13th nibble onward, each nibble appearing on `out_nib` with `out_vld` high one clock after the enabled edge that accepted it; no destination nibble is ever forwarded.
- R3: A frame whose twelve destination nibbles are all 4'hF sets `bcast` and is accepted in filtering mode.
- R4: In filtering mode, a frame whose destination matches neither address sets `addr_err` one clock after the enabled edge of its 12th nibble, and none of its nibbles is forwarded.
- R5: In pass-through mode, all nibbles of a frame, destination included, are forwarded with one clock of latency; `addr_err` stays 0 and `bcast` still reports an all-ones destination.
- R6: Destination byte 0 is `station_addr[47:40]`, bytes follow in transmit order, and within each byte the low nibble arrives first.
- R7: An enabled edge with `in_vld` and `abort` both high clears `out_vld`, `addr_err` and `bcast` and keeps them at 0 for the rest of the frame; the following frame is handled normally.
- R8: Outputs and internal state change only on clock edges where `ce` is high.
- R9: An enabled edge with `in_vld` low clears `out_vld`, `addr_err` and `bcast`; a frame shorter than 12 nibbles never raises a flag and forwards nothing in filtering mode.
- R10: `filt_en` is sampled at the first nibble of each frame; changing it later in the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce | input | 1 | Clock enable; the stream advances only when high |
| filt_en | input | 1 | 1 selects filtering, 0 selects pass-through |
| station_addr | input | 48 | Station address, byte 0 in bits 47:40 |
| in_vld | input | 1 | Input nibble valid, high for the whole frame |
| in_nib | input | 4 | Input nibble |
| abort | input | 1 | Drop the current frame |
| out_vld | output | 1 | Output nibble valid |
| out_nib | output | 4 | Output nibble |
| addr_err | output | 1 | Destination matched neither address (filtering mode) |
| bcast | output | 1 | Destination is all ones |

## Verification
The hardest situations to reach are those where a decision coincides with another event: an abort arriving on exactly the 12th nibble, the enable strobe dropping on the cycles around the address decision, and the mode input changing after the first nibble of a frame. The stimulus drives frames through a task that takes an abort position, a mode-toggle position and a pseudo-random enable-gap pattern, so each of these collisions is placed deliberately. A behavioural model built on a queue of received destination nibbles predicts every output on every clock.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_ADDR = 2'd1,
      FS_BODY = 2'd2,
      FS_DROP = 2'd3
   } rxaf_state_e;

endpackage

// File: rtl/rxaf_frame_ctl.sv
module rxaf_frame_ctl
   import rxaf_pkg::*;
#(
   parameter int ADDR_NIBS = 12,
   parameter int IDX_W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             in_vld,
   input  logic             abort,
   input  logic             filt_en,
   output rxaf_state_e      state,
   output logic [IDX_W-1:0] idx,
   output logic             en_now,
   output logic             last
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ADDR_NIBS - 1);

   logic en_q;

   assign en_now = (state == FS_IDLE) ? filt_en : en_q;
   assign last   = (state == FS_ADDR) && (idx == LAST_IDX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= FS_IDLE;
         idx   <= '0;
         en_q  <= 1'b0;
      end else if (ce) begin
         if (!in_vld) begin
            state <= FS_IDLE;
            idx   <= '0;
         end else if (abort || state == FS_DROP) begin
            state <= FS_DROP;
         end else begin
            en_q <= en_now;
            case (state)
               FS_IDLE: begin
                  state <= FS_ADDR;
                  idx   <= IDX_W'(1);
               end
               FS_ADDR: begin
                  if (last) state <= FS_BODY;
                  else      idx   <= idx + 1'b1;
               end
               default: state <= FS_BODY;
            endcase
         end
      end
   end

endmodule

// File: rtl/rxaf_addr_cmp.sv
module rxaf_addr_cmp #(
   parameter int NIB_W     = 4,
   parameter int ADDR_W    = 48,
   parameter int ADDR_NIBS = 12,
   parameter int IDX_W     = 4,
   parameter bit BUFFERED  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              first,
   input  logic [IDX_W-1:0]  idx,
   input  logic [NIB_W-1:0]  nib,
   input  logic [ADDR_W-1:0] station,
   output logic              hit_now,
   output logic              bc_now
);

   // Expected nibble at arrival position i: byte i/2 from the top, low half first.
   function automatic logic [NIB_W-1:0] exp_nib(input logic [ADDR_W-1:0] st,
                                                input logic [IDX_W-1:0]  i);
      int         byte_i;
      logic [7:0] b;
      byte_i = int'(i) >> 1;
      b      = 8'(st >> (ADDR_W - 8 - 8 * byte_i));
      return i[0] ? b[7:4] : b[3:0];
   endfunction

   generate
      if (BUFFERED) begin : g_buffered
         logic [ADDR_W-1:0] nib_buf;
         logic [ADDR_W-1:0] seen_vec;
         logic [ADDR_W-1:0] ref_vec;

         always_ff @(posedge clk) begin
            if (adv) nib_buf[idx*NIB_W +: NIB_W] <= nib;
         end

         always_comb begin
            seen_vec = nib_buf;
            seen_vec[idx*NIB_W +: NIB_W] = nib;
            for (int k = 0; k < ADDR_NIBS; k++)
               ref_vec[k*NIB_W +: NIB_W] = exp_nib(station, IDX_W'(k));
         end

         assign hit_now = (seen_vec == ref_vec);
         assign bc_now  = &seen_vec;
      end else begin : g_running
         logic m_run, b_run;
         logic m_base, b_base;

         assign m_base  = first ? 1'b1 : m_run;
         assign b_base  = first ? 1'b1 : b_run;
         assign hit_now = m_base && (nib == exp_nib(station, idx));
         assign bc_now  = b_base && (&nib);

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               m_run <= 1'b1;
               b_run <= 1'b1;
            end else if (adv) begin
               m_run <= hit_now;
               b_run <= bc_now;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rxaf_out_stage.sv
module rxaf_out_stage
   import rxaf_pkg::*;
#(
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ce,
   input  logic             in_vld,
   input  logic             abort,
   input  rxaf_state_e      state,
   input  logic             en_now,
   input  logic             last,
   input  logic             hit_now,
   input  logic             bc_now,
   input  logic [NIB_W-1:0] in_nib,
   output logic             out_vld,
   output logic [NIB_W-1:0] out_nib,
   output logic             addr_err,
   output logic             bcast
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_nib  <= '0;
         addr_err <= 1'b0;
         bcast    <= 1'b0;
      end else if (ce) begin
         if (!in_vld || abort || state == FS_DROP) begin
            out_vld  <= 1'b0;
            out_nib  <= '0;
            addr_err <= 1'b0;
            bcast    <= 1'b0;
         end else begin
            out_vld <= en_now ? (state == FS_BODY && !addr_err) : 1'b1;
            out_nib <= in_nib;
            if (last) begin
               bcast    <= bc_now;
               addr_err <= en_now && !(hit_now || bc_now);
            end
         end
      end
   end

   assert_drop_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FS_DROP) |-> (!out_vld && !addr_err && !bcast));

   assert_idle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && !in_vld) |=> (!out_vld && !addr_err && !bcast));

   assert_hold_no_ce_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ce |=> ($stable(out_vld) && $stable(out_nib) && $stable(addr_err) && $stable(bcast)));

   assert_err_blocks_out_R4: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> !out_vld);

   assert_addr_hidden_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == FS_ADDR && en_now) |-> !out_vld);

endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
   import rxaf_pkg::*;
#(
   parameter int NIB_W    = 4,
   parameter int ADDR_W   = 48,
   parameter bit BUFFERED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce,
   input  logic              filt_en,
   input  logic [ADDR_W-1:0] station_addr,
   input  logic              in_vld,
   input  logic [NIB_W-1:0]  in_nib,
   input  logic              abort,
   output logic              out_vld,
   output logic [NIB_W-1:0]  out_nib,
   output logic              addr_err,
   output logic              bcast
);

   localparam int ADDR_NIBS = ADDR_W / NIB_W;
   localparam int IDX_W     = $clog2(ADDR_NIBS);

   generate
      if (NIB_W != 4) begin : g_bad_nib
         $error("eth_rx_addr_filter: NIB_W must be 4");
      end
      if ((ADDR_W % 8) != 0 || ADDR_W < 16) begin : g_bad_addr
         $error("eth_rx_addr_filter: ADDR_W must be a byte multiple of at least 16");
      end
   endgenerate

   rxaf_state_e      state;
   logic [IDX_W-1:0] idx;
   logic             en_now, last, adv, hit_now, bc_now;

   assign adv = ce && in_vld && !abort && (state == FS_IDLE || state == FS_ADDR);

   rxaf_frame_ctl #(.ADDR_NIBS(ADDR_NIBS), .IDX_W(IDX_W)) i_ctl (
      .clk(clk), .rst_n(rst_n), .ce(ce), .in_vld(in_vld), .abort(abort),
      .filt_en(filt_en), .state(state), .idx(idx), .en_now(en_now), .last(last)
   );

   rxaf_addr_cmp #(.NIB_W(NIB_W), .ADDR_W(ADDR_W), .ADDR_NIBS(ADDR_NIBS),
                   .IDX_W(IDX_W), .BUFFERED(BUFFERED)) i_cmp (
      .clk(clk), .rst_n(rst_n), .adv(adv), .first(state == FS_IDLE),
      .idx(idx), .nib(in_nib), .station(station_addr),
      .hit_now(hit_now), .bc_now(bc_now)
   );

   rxaf_out_stage #(.NIB_W(NIB_W)) i_out (
      .clk(clk), .rst_n(rst_n), .ce(ce), .in_vld(in_vld), .abort(abort),
      .state(state), .en_now(en_now), .last(last), .hit_now(hit_now),
      .bc_now(bc_now), .in_nib(in_nib), .out_vld(out_vld), .out_nib(out_nib),
      .addr_err(addr_err), .bcast(bcast)
   );

endmodule

// File: tb/test_eth_rx_addr_filter.sv
module test_eth_rx_addr_filter;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ce = 1'b0;
   logic        filt_en = 1'b1;
   logic [47:0] station_addr = 48'h0123456789AB;
   logic        in_vld = 1'b0;
   logic [3:0]  in_nib = 4'h0;
   logic        abort = 1'b0;
   logic        out_vld;
   logic [3:0]  out_nib;
   logic        addr_err;
   logic        bcast;

   always #4 clk = ~clk;

   eth_rx_addr_filter i_eth_rx_addr_filter (
      .clk(clk), .rst_n(rst_n), .ce(ce), .filt_en(filt_en),
      .station_addr(station_addr), .in_vld(in_vld), .in_nib(in_nib),
      .abort(abort), .out_vld(out_vld), .out_nib(out_nib),
      .addr_err(addr_err), .bcast(bcast)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   string cur_req = "R1";

   // Behavioural reference model.
   int       ms = 0;          // 0 idle, 1 address, 2 body, 3 dropped
   bit       m_en = 1'b0;
   bit       m_ce = 1'b0;
   bit       en_cur, hit, bc;
   int       mq[$];
   bit       e_vld = 0, e_err = 0, e_bc = 0;
   bit [3:0] e_nib = 0;

   function automatic bit [3:0] dnib(input logic [47:0] a, input int k);
      logic [7:0] b;
      b = a[47 - 8*(k/2) -: 8];
      return (k % 2) ? b[7:4] : b[3:0];
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ms = 0; m_en = 0; m_ce = 0; mq.delete();
         e_vld = 0; e_nib = 0; e_err = 0; e_bc = 0;
      end else begin
         m_ce = ce;
         if (ce) begin
            if (!in_vld) begin
               ms = 0; mq.delete();
               e_vld = 0; e_nib = 0; e_err = 0; e_bc = 0;
            end else if (abort || ms == 3) begin
               ms = 3;
               e_vld = 0; e_nib = 0; e_err = 0; e_bc = 0;
            end else begin
               en_cur = (ms == 0) ? filt_en : m_en;
               m_en   = en_cur;
               e_vld  = en_cur ? (ms == 2 && !e_err) : 1'b1;
               e_nib  = in_nib;
               if (ms != 2) begin
                  mq.push_back(int'(in_nib));
                  ms = 1;
                  if (mq.size() == 12) begin
                     hit = 1; bc = 1;
                     for (int k = 0; k < 12; k++) begin
                        if (mq[k] != int'(dnib(station_addr, k))) hit = 0;
                        if (mq[k] != 15) bc = 0;
                     end
                     e_bc  = bc;
                     e_err = en_cur && !(hit || bc);
                     ms    = 2;
                  end
               end
            end
         end
      end
   end

   // Per-clock comparison and frame-level observation, away from the active edge.
   int out_cnt = 0;
   bit err_seen = 0, bc_seen = 0;

   always @(negedge clk) begin
      if (!done) begin
         checks++;
         if (out_vld !== e_vld || addr_err !== e_err || bcast !== e_bc ||
             (e_vld && out_nib !== e_nib)) begin
            errors++;
            $display("FAIL %s: vld/nib/err/bc actual %0b/%h/%0b/%0b expected %0b/%h/%0b/%0b",
                     cur_req, out_vld, out_nib, addr_err, bcast, e_vld, e_nib, e_err, e_bc);
         end
         if (rst_n && m_ce && out_vld) out_cnt++;
         if (addr_err) err_seen = 1;
         if (bcast) bc_seen = 1;
      end
   end

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   bit [7:0] lfsr = 8'hA5;

   task automatic send_frame(input logic [47:0] dest, input int body,
                             input int abort_at, input int toggle_at, input bit gaps);
      int n = 0;
      int total = 12 + body;
      out_cnt = 0; err_seen = 0; bc_seen = 0;
      while (n < total) begin
         @(negedge clk);
         in_vld = 1'b1;
         in_nib = (n < 12) ? dnib(dest, n) : 4'((n * 7 + 3) % 16);
         lfsr   = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         ce     = gaps ? lfsr[0] : 1'b1;
         abort  = (n == abort_at);
         if (n == toggle_at && ce) filt_en = !filt_en;
         if (ce) n++;
      end
      @(negedge clk);
      in_vld = 1'b0; ce = 1'b1; abort = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         done = 1'b1;
         summary();
         $finish;
      end
   end

   initial begin
      cur_req = "R1";
      repeat (4) @(negedge clk);
      check_eq("R1 out_vld in reset", int'(out_vld), 0);
      rst_n = 1'b1; ce = 1'b1;
      repeat (3) @(negedge clk);
      check_eq("R1 flags after reset", int'(addr_err | bcast), 0);

      cur_req = "R2"; filt_en = 1'b1;
      send_frame(station_addr, 20, -1, -1, 0);
      check_eq("R2 forwarded count", out_cnt, 20);
      check_eq("R2 no error", int'(err_seen), 0);

      cur_req = "R3";
      send_frame(48'hFFFFFFFFFFFF, 10, -1, -1, 0);
      check_eq("R3 broadcast flag", int'(bc_seen), 1);
      check_eq("R3 broadcast forwarded", out_cnt, 10);

      cur_req = "R4";
      send_frame(48'h0123456789AC, 10, -1, -1, 0);
      check_eq("R4 error flag", int'(err_seen), 1);
      check_eq("R4 nothing forwarded", out_cnt, 0);

      cur_req = "R6";
      send_frame(48'h1032547698BA, 6, -1, -1, 0);
      check_eq("R6 swapped nibbles rejected", int'(err_seen), 1);
      check_eq("R6 swapped forwarded", out_cnt, 0);

      cur_req = "R5"; filt_en = 1'b0;
      send_frame(48'h00AA00BB00CC, 8, -1, -1, 0);
      check_eq("R5 full frame forwarded", out_cnt, 20);
      check_eq("R5 no error", int'(err_seen), 0);
      send_frame(48'hFFFFFFFFFFFF, 4, -1, -1, 0);
      check_eq("R5 broadcast in pass-through", int'(bc_seen), 1);

      cur_req = "R7"; filt_en = 1'b1;
      send_frame(station_addr, 12, 16, -1, 0);
      check_eq("R7 abort in body", out_cnt, 4);
      send_frame(station_addr, 6, 5, -1, 0);
      check_eq("R7 abort in address", out_cnt, 0);
      send_frame(station_addr, 6, 11, -1, 0);
      check_eq("R7 abort on 12th nibble", out_cnt + int'(err_seen | bc_seen), 0);
      send_frame(station_addr, 5, -1, -1, 0);
      check_eq("R7 next frame normal", out_cnt, 5);

      cur_req = "R8";
      send_frame(station_addr, 16, -1, -1, 1);
      check_eq("R8 gaps match count", out_cnt, 16);
      send_frame(48'h0123456789AA, 9, -1, -1, 1);
      check_eq("R8 gaps mismatch", int'(err_seen), 1);

      cur_req = "R9";
      send_frame(station_addr, -5, -1, -1, 0);
      check_eq("R9 short frame quiet", out_cnt + int'(err_seen | bc_seen), 0);

      cur_req = "R10"; filt_en = 1'b1;
      send_frame(station_addr, 7, -1, 3, 0);
      check_eq("R10 enable kept", out_cnt, 7);
      send_frame(48'h111111111111, 7, -1, 3, 0);
      check_eq("R10 disable kept", out_cnt, 19);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule